// File: doc/BRIEF.md
# Timer and Watchdog with Shared Divider

This block combines an 8-bit timer/counter and an 8-bit watchdog counter that share one 8-bit binary divider. The timer counts either instruction-cycle ticks or edges on an external pin, and the pin is synchronised before its edges are detected. The divider works in one of two ways. Placed in front of the timer, it stretches the timer's reach to 16 bits. Placed behind the watchdog, it lengthens the timeout. It never serves both at once.

Software sets the mode through a control register on the write port. The same port loads the timer. The divider itself has no bus access, and a timer load or a watchdog clear zeroes it. A timer rollover from 0xFF to 0x00 gives a one-cycle interrupt pulse when that pulse is enabled. No flag holds the event, so software must read the timer value to see that an overflow happened. The watchdog counts a slow tick input only while a static enable is high. Its timeout is also a one-cycle pulse.

Top module: `tmwd_top`

## Requirements
- R1: After reset, the timer value, the interrupt and the timeout are 0. The control register is 0: internal ticks, rising edge, divider on the timer, tap 0, interrupt disabled.
- R2: Control bit 5 = 0 selects the internal tick. With control bit 3 = 1, the timer adds one for each cycle in which `cyc_en` is high, and it changes by at most one per clock.
- R3: Control bit 5 = 1 selects the external pin, and control bit 4 picks the edge (0 = rising, 1 = falling). A pin change that is set up before a clock edge first shows as a timer increment after the third rising clock edge.
- R4: Control bit 3 = 0 puts the divider in front of the timer. Control bits [2:0] = k then advance the timer once per 2^(k+1) source events.
- R5: A write with `wr_sel` = 0 loads `wr_data` into the timer on the next clock and zeroes the divider. A load wins over an increment in the same cycle.
- R6: With control bit 6 = 1, a rollover from 0xFF to 0x00 gives a one-cycle `tmr_irq` in the cycle in which `tmr_val` first reads 0. There is no pulse when bit 6 = 0, and none when a load takes the place of the rollover.
- R7: The watchdog counter advances on `wdt_tick` only while `wdt_en` is high. While `wdt_en` is low, the counter is held at zero and `wdt_timeout` stays low.
- R8: With control bit 3 = 0, `wdt_timeout` is a one-cycle pulse on every 256th enabled watchdog tick.
- R9: With control bit 3 = 1 and tap k, `wdt_timeout` pulses once every 256·2^(k+1) enabled watchdog ticks.
- R10: `wdt_clr` zeroes the watchdog counter and the divider, and it suppresses a timeout that would fall in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle tick |
| ext_pin | input | 1 | Asynchronous external count pin |
| wdt_tick | input | 1 | Watchdog tick, one cycle wide |
| wdt_en | input | 1 | Static watchdog enable |
| wdt_clr | input | 1 | Watchdog clear strobe |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = timer, 1 = control register |
| wr_data | input | 8 | Write data |
| tmr_val | output | 8 | Current timer value |
| tmr_irq | output | 1 | Rollover interrupt pulse |
| wdt_timeout | output | 1 | Watchdog timeout pulse |

## Verification
Two pairs of events can land in the same clock, and the bench forces each pair on purpose.

- **Watchdog clear against timeout.** The watchdog counter is driven to 0xFF, and then a tick and a clear are applied in the same cycle. The check is that no timeout appears and that counting restarts from zero.
- **Timer load against rollover.** The timer is loaded with 0xFF and left to count. A second load is then timed to fall on the rollover cycle. The check is that the loaded value wins and that no interrupt appears.

Random traffic also mixes loads, clears and control changes across both divider assignments. Every cycle is compared against a reference model in the bench.

// File: rtl/tmwd_pkg.sv
package tmwd_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;
  localparam int WDT_W  = 8;
  localparam int TAP_W  = $clog2(DIV_W);

  // control register layout (bits 6..0 of the write data)
  typedef struct packed {
    logic             irq_en;    // bit 6
    logic             src_ext;   // bit 5
    logic             edge_fall; // bit 4
    logic             div_wdt;   // bit 3
    logic [TAP_W-1:0] tap;       // bits 2..0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmwd_edge_src.sv
module tmwd_edge_src #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_en,
  input  logic ext_pin,
  input  logic src_ext,
  input  logic edge_fall,
  output logic ev
);
  logic [SYNC_N:0] chain_q, chain_d;
  logic            rise, fall;

  always_comb begin
    chain_d = {chain_q[SYNC_N-1:0], ext_pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rise = chain_q[SYNC_N-1] & ~chain_q[SYNC_N];
  assign fall = ~chain_q[SYNC_N-1] & chain_q[SYNC_N];

  always_comb begin
    if (src_ext) ev = edge_fall ? fall : rise;
    else         ev = cyc_en;
  end
endmodule

// File: rtl/tmwd_divider.sv
module tmwd_divider #(
  parameter int DIV_W = 8,
  localparam int TAP_W = $clog2(DIV_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  input  logic [TAP_W-1:0] tap_sel,
  output logic             carry
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] all_ones;

  always_comb begin
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // the selected tap toggles 1->0 on the event that finds the lower bits all set
  for (genvar k = 0; k < DIV_W; k++) begin : g_tap
    assign all_ones[k] = &cnt_q[k:0];
  end

  assign carry = all_ones[tap_sel];
endmodule

// File: rtl/tmwd_wdt.sv
module tmwd_wdt #(
  parameter int WDT_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic tick,
  input  logic clr,
  output logic ovf
);
  logic [WDT_W-1:0] cnt_q, cnt_d;
  logic             step;

  assign step = en & tick;

  always_comb begin
    if (clr || !en) cnt_d = '0;
    else if (step)  cnt_d = cnt_q + 1'b1;
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign ovf = step & (&cnt_q);
endmodule

// File: rtl/tmwd_top.sv
module tmwd_top
  import tmwd_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_en,
  input  logic              ext_pin,
  input  logic              wdt_tick,
  input  logic              wdt_en,
  input  logic              wdt_clr,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] tmr_val,
  output logic              tmr_irq,
  output logic              wdt_timeout
);
  ctrl_t             ctrl_q, ctrl_d;
  logic [DATA_W-1:0] tmr_q, tmr_d;
  logic              irq_q, irq_d;
  logic              to_q, to_d;
  logic              ev, wovf, carry;
  logic              div_inc, div_clr, tmr_inc, tmr_wr, ctrl_wr;

  tmwd_edge_src #(.SYNC_N(SYNC_N)) u_src (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .src_ext(ctrl_q.src_ext), .edge_fall(ctrl_q.edge_fall), .ev(ev)
  );

  tmwd_wdt #(.WDT_W(WDT_W)) u_wdt (
    .clk(clk), .rst_n(rst_n), .en(wdt_en), .tick(wdt_tick),
    .clr(wdt_clr), .ovf(wovf)
  );

  tmwd_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(div_clr), .inc(div_inc),
    .tap_sel(ctrl_q.tap), .carry(carry)
  );

  assign tmr_wr  = wr_en & ~wr_sel;
  assign ctrl_wr = wr_en & wr_sel;
  assign div_clr = tmr_wr | wdt_clr;
  assign div_inc = ctrl_q.div_wdt ? wovf : ev;
  assign tmr_inc = ctrl_q.div_wdt ? ev : (ev & carry);

  always_comb begin
    ctrl_d = ctrl_wr ? ctrl_t'(wr_data[CTRL_W-1:0]) : ctrl_q;

    if (tmr_wr)       tmr_d = wr_data;
    else if (tmr_inc) tmr_d = tmr_q + 1'b1;
    else              tmr_d = tmr_q;

    irq_d = ctrl_q.irq_en & tmr_inc & (&tmr_q) & ~tmr_wr;
    to_d  = wovf & ~wdt_clr & (ctrl_q.div_wdt ? carry : 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      tmr_q  <= '0;
      irq_q  <= 1'b0;
      to_q   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      tmr_q  <= tmr_d;
      irq_q  <= irq_d;
      to_q   <= to_d;
    end
  end

  assign tmr_val     = tmr_q;
  assign tmr_irq     = irq_q;
  assign wdt_timeout = to_q;
endmodule

// File: rtl/tmwd_chk.sv
module tmwd_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cyc_en,
  input logic       ext_pin,
  input logic       wdt_tick,
  input logic       wdt_en,
  input logic       wdt_clr,
  input logic       wr_en,
  input logic       wr_sel,
  input logic [7:0] wr_data,
  input logic [7:0] tmr_val,
  input logic       tmr_irq,
  input logic       wdt_timeout
);
  AST_TMR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !wr_sel) |=> (tmr_val == $past(tmr_val)) || (tmr_val == $past(tmr_val) + 8'd1)); // R2

  AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> tmr_val == $past(wr_data)); // R5

  AST_IRQ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |-> tmr_val == 8'd0); // R6

  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |=> !tmr_irq); // R6

  AST_WDT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_en |=> !wdt_timeout); // R7

  AST_TO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_timeout |=> !wdt_timeout); // R8

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_clr |=> !wdt_timeout); // R10
endmodule

bind tmwd_top tmwd_chk chk_i (.*);

// File: tb/tmwd_top_tb_top.sv
module tmwd_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk, rst_n;
  logic       cyc_en, ext_pin, wdt_tick, wdt_en, wdt_clr, wr_en, wr_sel;
  logic [7:0] wr_data;
  logic [7:0] tmr_val;
  logic       tmr_irq, wdt_timeout;

  int n_chk = 0, n_fail = 0, cyc = 0;

  // reference state
  int m_tmr, m_div, m_wcnt, m_ctrl, m_irq, m_to;
  int m_s1, m_s2, m_s3;

  tmwd_top dut_i (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
    .wdt_tick(wdt_tick), .wdt_en(wdt_en), .wdt_clr(wdt_clr),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tmr_val(tmr_val), .tmr_irq(tmr_irq), .wdt_timeout(wdt_timeout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG_CYCLES) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired: actual=%0d expected<%0d", cyc, WATCHDOG_CYCLES);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  function automatic bit low_ones(int v, int k);
    int mask = (1 << (k + 1)) - 1;
    return (v & mask) == mask;
  endfunction

  task automatic model_reset();
    m_tmr = 0; m_div = 0; m_wcnt = 0; m_ctrl = 0; m_irq = 0; m_to = 0;
    m_s1 = 0; m_s2 = 0; m_s3 = 0;
  endtask

  task automatic model_update();
    bit ext, fall, onwdt, ie, ev, wt, wovf, cy, tinc, twr, cwr, dinc;
    int k;
    ie = m_ctrl[6]; ext = m_ctrl[5]; fall = m_ctrl[4]; onwdt = m_ctrl[3]; k = m_ctrl & 7;
    if (ext) ev = fall ? (!m_s2 && m_s3) : (m_s2 && !m_s3);
    else     ev = cyc_en;
    wt   = wdt_en && wdt_tick;
    wovf = wt && (m_wcnt == 255);
    cy   = low_ones(m_div, k);
    twr  = wr_en && !wr_sel;
    cwr  = wr_en && wr_sel;
    tinc = onwdt ? ev : (ev && cy);
    dinc = onwdt ? wovf : ev;
    m_irq = (ie && tinc && m_tmr == 255 && !twr) ? 1 : 0;
    m_to  = (wovf && !wdt_clr && (!onwdt || cy)) ? 1 : 0;
    if (twr) m_tmr = wr_data;
    else if (tinc) m_tmr = (m_tmr + 1) % 256;
    if (twr || wdt_clr) m_div = 0;
    else if (dinc) m_div = (m_div + 1) % 256;
    if (wdt_clr || !wdt_en) m_wcnt = 0;
    else if (wt) m_wcnt = (m_wcnt + 1) % 256;
    if (cwr) m_ctrl = wr_data & 8'h7f;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    model_update();
    @(negedge clk);
    chk({tag, " tmr_val"}, tmr_val, m_tmr);
    chk({tag, " tmr_irq"}, tmr_irq, m_irq);
    chk({tag, " wdt_timeout"}, wdt_timeout, m_to);
  endtask

  task automatic wr(bit sel, int data, string tag);
    wr_en = 1'b1; wr_sel = sel; wr_data = data[7:0];
    step(tag);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  initial begin
    int irqs, tos, base;
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; cyc_en = 0; ext_pin = 0; wdt_tick = 0; wdt_en = 0;
    wdt_clr = 0; wr_en = 0; wr_sel = 0; wr_data = 0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset tmr_val", tmr_val, 0);
    chk("R1 reset tmr_irq", tmr_irq, 0);
    chk("R1 reset wdt_timeout", wdt_timeout, 0);
    rst_n = 1'b1;
    // R1: default control = internal ticks, tap 0 -> divide by 2
    cyc_en = 1;
    idle(4, "R1 default");
    chk("R1 default divide by 2", tmr_val, 2);

    // R2: internal ticks, no prescale
    wr(1, 8'h08, "R2 ctrl");
    wr(0, 0, "R2 load");
    cyc_en = 1; idle(5, "R2");
    cyc_en = 0; idle(3, "R2");
    chk("R2 five ticks", tmr_val, 5);

    // R3: external rising edge latency
    wr(1, 8'h28, "R3 ctrl");
    wr(0, 0, "R3 load");
    ext_pin = 1; step("R3"); step("R3");
    chk("R3 not yet counted", tmr_val, 0);
    step("R3");
    chk("R3 rising edge counted", tmr_val, 1);
    ext_pin = 0; idle(4, "R3");
    chk("R3 falling ignored", tmr_val, 1);
    wr(1, 8'h38, "R3 ctrl fall");
    ext_pin = 1; idle(4, "R3");
    ext_pin = 0; idle(4, "R3");
    chk("R3 falling edge counted", tmr_val, 2);

    // R4: prescaler tap 2 -> divide by 8
    wr(1, 8'h02, "R4 ctrl");
    wr(0, 0, "R4 load");
    cyc_en = 1; idle(24, "R4");
    chk("R4 divide by 8", tmr_val, 3);
    cyc_en = 0;

    // R5/R6: rollover with interrupt enabled
    wr(1, 8'h48, "R6 ctrl");
    wr(0, 8'hfe, "R5 load");
    chk("R5 load value", tmr_val, 254);
    cyc_en = 1; irqs = 0;
    for (int i = 0; i < 3; i++) begin step("R6"); irqs += tmr_irq; end
    chk("R6 one interrupt", irqs, 1);
    // load on the rollover cycle wins
    wr(0, 8'hff, "R5 load ff");
    wr(0, 8'h40, "R5 load over rollover");
    chk("R5 load wins", tmr_val, 64);
    chk("R6 no irq on load", tmr_irq, 0);
    wr(1, 8'h08, "R6 ctrl ie off");
    wr(0, 8'hff, "R6 load");
    step("R6"); chk("R6 disabled no irq", tmr_irq, 0);
    cyc_en = 0;

    // R7: watchdog disabled
    wdt_en = 0; wdt_tick = 1; tos = 0;
    for (int i = 0; i < 300; i++) begin step("R7"); tos += wdt_timeout; end
    chk("R7 no timeout when off", tos, 0);

    // R8: divider on timer, 256 ticks per timeout
    wr(1, 8'h00, "R8 ctrl");
    wdt_en = 1; wdt_clr = 1; step("R8"); wdt_clr = 0;
    tos = 0;
    for (int i = 0; i < 512; i++) begin step("R8"); tos += wdt_timeout; end
    chk("R8 two timeouts in 512", tos, 2);

    // R9: postscaler tap 0 -> 512 ticks per timeout
    wr(1, 8'h08, "R9 ctrl");
    wdt_clr = 1; step("R9"); wdt_clr = 0;
    tos = 0;
    for (int i = 0; i < 1100; i++) begin step("R9"); tos += wdt_timeout; end
    chk("R9 two timeouts in 1100", tos, 2);

    // R10: clear on the timeout cycle
    wr(1, 8'h00, "R10 ctrl");
    wdt_clr = 1; step("R10"); wdt_clr = 0;
    idle(255, "R10");
    wdt_clr = 1; step("R10"); wdt_clr = 0;
    chk("R10 clear suppresses timeout", wdt_timeout, 0);
    tos = 0;
    for (int i = 0; i < 255; i++) begin step("R10"); tos += wdt_timeout; end
    chk("R10 counting restarted", tos, 0);
    step("R10"); chk("R10 timeout after 256", wdt_timeout, 1);

    // random traffic across all modes (R2..R10 via the model)
    base = 0;
    for (int i = 0; i < 20000; i++) begin
      cyc_en   = ($urandom % 3) != 0;
      wdt_tick = ($urandom % 2) == 0;
      if ($urandom % 7 == 0) ext_pin = ~ext_pin;
      if ($urandom % 1000 == 0) wdt_en = ~wdt_en;
      wdt_clr = ($urandom % 600) == 0;
      wr_en = 0;
      if ($urandom % 250 == 0) begin wr_en = 1; wr_sel = 1; wr_data = 8'($urandom) & 8'h7b; end
      else if ($urandom % 300 == 0) begin wr_en = 1; wr_sel = 0; wr_data = 8'($urandom); end
      step("R4 random");
      base += tmr_irq;
    end
    wr_en = 0; wdt_clr = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule